// File: doc/BRIEF.md
# DRAM Host Refresh Row Scanner

This block keeps an asynchronous DRAM alive when the memory has no refresh logic of its own. A free-running down-counter produces a refresh tick once per programmable period. On each tick the scanner asks an access arbiter for the bus, holding a request until the grant arrives, so a normal access in progress is never cut short. Once granted, it drives a row-only strobe for a fixed number of cycles with the current row address, then moves its row pointer to the next row.

The sweep covers rows 0 up to a programmable last row, not the whole device. Each row is visited once every (last row + 1) ticks, so a system that keeps only a small part of the memory alive can choose a long tick period, and a system that keeps all of it alive must choose a short one. Refresh work is spread as one row per tick and never done as a batch. If a tick arrives while the previous refresh has not finished, that tick is dropped and a sticky overdue flag records the missed deadline until it is cleared.

The sequencer has three states. IDLE waits for a tick. WAIT holds the request and waits for a grant. STROBE drives the row strobe for RAS_CYC cycles. There are four transitions: IDLE to WAIT on a tick, WAIT to STROBE on a grant, STROBE to STROBE while the strobe count runs, and STROBE to IDLE when the count ends. The row pointer moves on that last transition.

Top module: `rfsh_scan`

## Requirements
- R1: While reset is low and in the first cycle after it, req_o, ras_o and overdue_o are 0 and row_o is 0.
- R2: With P the value of period_i during reset, the first req_o goes high P+1 cycles after reset is released. Later ticks come every P+1 cycles.
- R3: Once high, req_o stays high in every cycle until gnt_i is sampled high.
- R4: row_o does not change while req_o or ras_o is high.
- R5: A grant sampled in a request cycle makes req_o drop and ras_o rise in the next cycle. ras_o then stays high for exactly RAS_CYC cycles (3 by default).
- R6: At the end of each strobe, the row pointer goes to row_o+1. If row_o is equal to or greater than last_row_i, it goes to 0 instead.
- R7: gnt_i has no effect when no request is pending. It starts no strobe and does not move the row pointer.
- R8: A tick that arrives while req_o or ras_o is high is dropped, and it sets overdue_o. overdue_o stays high until overdue_clr_i is high for one cycle. Refreshes that complete in time never set it.
- R9: A new period_i value does not change the countdown already running. It takes effect from the next counter wrap.
- R10: req_o and ras_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the tick period is loaded while it is low |
| period_i | input | CNT_W | Tick period minus one, sampled at reset and at each counter wrap |
| last_row_i | input | ROW_W | Highest row included in the sweep |
| gnt_i | input | 1 | Grant from the access arbiter |
| overdue_clr_i | input | 1 | Clears the overdue flag |
| req_o | output | 1 | Refresh request to the arbiter |
| ras_o | output | 1 | Row strobe for a row-only refresh cycle |
| row_o | output | ROW_W | Row address to refresh |
| overdue_o | output | 1 | Sticky flag: a tick arrived before the previous refresh finished |

## Verification
Each result has a fixed arrival time. A tick seen in the counter's zero cycle raises req_o one clock later. That gives P+1 cycles from reset release, or from the previous request. A grant sampled with req_o high shows as ras_o one clock later, and the pointer change is visible in the first cycle after ras_o falls. The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from a known event, such as reset release, request rise or grant, and checks each output at the exact edge count where it is due. It does not poll loosely, except while waiting for a request, and there it compares the measured count with the expected interval.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_STROBE = 2'd2
    } rfsh_state_t;

endpackage

// File: rtl/rfsh_tick.sv
// Free-running down-counter that paces refresh ticks.
module rfsh_tick #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == '0);

    // The period is sampled only during reset and at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= period_i;
        end else if (wrap) begin
            cnt_q <= period_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = rst_n && wrap;

endmodule

// File: rtl/rfsh_row_ptr.sv
// Row pointer sweeping 0..last_row_i, wrapping back to 0.
module rfsh_row_ptr #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [ROW_W-1:0] last_row_i,
    output logic [ROW_W-1:0] row_o
);

    logic [ROW_W-1:0] row_q;
    logic             at_end;

    // A span reduced below the pointer also wraps.
    assign at_end = (row_q >= last_row_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (adv_i) begin
            row_q <= at_end ? '0 : row_q + 1'b1;
        end
    end

    assign row_o = row_q;

endmodule

// File: rtl/rfsh_seq.sv
// Request / strobe sequencer plus overdue flag.
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int RAS_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic gnt_i,
    input  logic ovd_clr_i,
    output logic req_o,
    output logic ras_o,
    output logic done_o,
    output logic overdue_o
);

    localparam int STB_W = (RAS_CYC < 2) ? 1 : $clog2(RAS_CYC);
    localparam logic [STB_W-1:0] STB_LAST = STB_W'(RAS_CYC - 1);

    rfsh_state_t      state_q, state_d;
    logic [STB_W-1:0] stb_q;
    logic             stb_end;
    logic             busy;
    logic             ovd_q;

    assign stb_end = (stb_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick_i) state_d = ST_WAIT;
            ST_WAIT:   if (gnt_i)  state_d = ST_STROBE;
            ST_STROBE: if (stb_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Strobe length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= '0;
        end else if (state_q == ST_WAIT && gnt_i) begin
            stb_q <= STB_LAST;
        end else if (state_q == ST_STROBE && !stb_end) begin
            stb_q <= stb_q - 1'b1;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        req_o  = 1'b0;
        ras_o  = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WAIT:   req_o = 1'b1;
            ST_STROBE: begin
                ras_o  = 1'b1;
                done_o = stb_end;
            end
            default:   ;
        endcase
    end

    // Overdue flag: a tick while a refresh is still open; set beats clear.
    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovd_q <= 1'b0;
        end else if (tick_i && busy) begin
            ovd_q <= 1'b1;
        end else if (ovd_clr_i) begin
            ovd_q <= 1'b0;
        end
    end

    assign overdue_o = ovd_q;

endmodule

// File: rtl/rfsh_scan.sv
// Top: host-side DRAM refresh row scanner.
module rfsh_scan #(
    parameter int CNT_W   = 16,
    parameter int ROW_W   = 12,
    parameter int RAS_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [ROW_W-1:0] last_row_i,
    input  logic             gnt_i,
    input  logic             overdue_clr_i,
    output logic             req_o,
    output logic             ras_o,
    output logic [ROW_W-1:0] row_o,
    output logic             overdue_o
);

    logic tick;
    logic done;

    rfsh_tick #(.CNT_W(CNT_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .tick_o   (tick)
    );

    rfsh_seq #(.RAS_CYC(RAS_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .gnt_i     (gnt_i),
        .ovd_clr_i (overdue_clr_i),
        .req_o     (req_o),
        .ras_o     (ras_o),
        .done_o    (done),
        .overdue_o (overdue_o)
    );

    rfsh_row_ptr #(.ROW_W(ROW_W)) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (done),
        .last_row_i (last_row_i),
        .row_o      (row_o)
    );

endmodule

// File: rtl/rfsh_scan_chk.sv
// Property checker, bound to every rfsh_scan instance.
module rfsh_scan_chk #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gnt_i,
    input logic             overdue_clr_i,
    input logic [ROW_W-1:0] last_row_i,
    input logic             req_o,
    input logic             ras_o,
    input logic [ROW_W-1:0] row_o,
    input logic             overdue_o
);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !gnt_i) |=> req_o);

    assert_row_stable_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> $stable(row_o));

    assert_row_stable_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_o && $past(ras_o)) |-> $stable(row_o));

    assert_grant_to_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && gnt_i) |=> (ras_o && !req_o));

    assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_o) |-> (row_o == (($past(row_o) >= $past(last_row_i)) ?
                                    '0 : $past(row_o) + 1'b1)));

    assert_idle_grant_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !ras_o && gnt_i) |=> !ras_o);

    assert_overdue_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overdue_o && !overdue_clr_i) |=> overdue_o);

    assert_overdue_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overdue_o) |-> $past(req_o || ras_o));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_o, ras_o}));

endmodule

bind rfsh_scan rfsh_scan_chk #(.ROW_W(ROW_W)) u_rfsh_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .gnt_i         (gnt_i),
    .overdue_clr_i (overdue_clr_i),
    .last_row_i    (last_row_i),
    .req_o         (req_o),
    .ras_o         (ras_o),
    .row_o         (row_o),
    .overdue_o     (overdue_o)
);

// File: tb/test_rfsh_scan.sv
`timescale 1ns/1ps
module test_rfsh_scan;

    localparam int CNT_W   = 8;
    localparam int ROW_W   = 4;
    localparam int RAS_CYC = 3;
    localparam int P0      = 9;
    localparam int VEC_N   = 8;
    // per request: grant delay in cycles, expected row (last row = 5)
    localparam int VEC_DLY [VEC_N] = '{0, 1, 2, 4, 3, 0, 2, 1};
    localparam int VEC_ROW [VEC_N] = '{0, 1, 2, 3, 4, 5, 0, 1};

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] period_i;
    logic [ROW_W-1:0] last_row_i;
    logic             gnt_i;
    logic             overdue_clr_i;
    logic             req_o;
    logic             ras_o;
    logic [ROW_W-1:0] row_o;
    logic             overdue_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rfsh_scan #(.CNT_W(CNT_W), .ROW_W(ROW_W), .RAS_CYC(RAS_CYC)) i_rfsh_scan (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_i      (period_i),
        .last_row_i    (last_row_i),
        .gnt_i         (gnt_i),
        .overdue_clr_i (overdue_clr_i),
        .req_o         (req_o),
        .ras_o         (ras_o),
        .row_o         (row_o),
        .overdue_o     (overdue_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!req_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (!req_o) check(1'b0, "R2 request timeout", 0, 1);
    endtask

    // Called at a falling edge where req_o is high.
    task automatic serve(input int dly, input int exp_row);
        int r0;
        int n;
        check(row_o == ROW_W'(exp_row), "R6 row of request", row_o, exp_row);
        r0 = row_o;
        for (int d = 0; d < dly; d++) begin
            @(negedge clk);
            check(req_o == 1'b1, "R3 request held", req_o, 1);
        end
        gnt_i = 1'b1;
        @(negedge clk);
        gnt_i = 1'b0;
        check(req_o == 1'b0 && ras_o == 1'b1, "R5 R10 grant to strobe",
              {req_o, ras_o}, 1);
        n = 0;
        while (ras_o && n < 20) begin
            check(row_o == ROW_W'(r0), "R4 row stable in strobe", row_o, r0);
            n++;
            @(negedge clk);
        end
        check(n == RAS_CYC, "R5 strobe length", n, RAS_CYC);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n         = 1'b0;
        period_i      = CNT_W'(P0);
        last_row_i    = ROW_W'(5);
        gnt_i         = 1'b0;
        overdue_clr_i = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(req_o == 0 && ras_o == 0 && overdue_o == 0 && row_o == 0,
              "R1 reset state", {req_o, ras_o, overdue_o, row_o}, 0);

        // R2: first request P+1 cycles after release
        rst_n = 1'b1;
        @(negedge clk);
        check(req_o == 0 && ras_o == 0 && overdue_o == 0 && row_o == 0,
              "R1 first cycle after reset", {req_o, ras_o, overdue_o, row_o}, 0);
        wait_req(n);
        check(n + 1 == P0 + 1, "R2 first request latency", n + 1, P0 + 1);

        // Vector table: grant delays and the row sweep with wrap (R3..R6)
        for (int i = 0; i < VEC_N; i++) begin
            if (i > 0) begin
                wait_req(n);
            end
            serve(VEC_DLY[i], VEC_ROW[i]);
        end
        check(overdue_o == 1'b0, "R8 no overdue when on time", overdue_o, 0);

        // R7: grant while idle is ignored
        gnt_i = 1'b1;
        @(negedge clk);
        gnt_i = 1'b0;
        check(ras_o == 1'b0 && req_o == 1'b0, "R7 idle grant no strobe",
              {req_o, ras_o}, 0);
        wait_req(n);
        check(row_o == ROW_W'(2), "R7 pointer unchanged by idle grant", row_o, 2);

        // R8: leave the request pending across a tick
        repeat (12) @(negedge clk);
        check(overdue_o == 1'b1, "R8 overdue set by late tick", overdue_o, 1);
        check(req_o == 1'b1, "R3 request held without grant", req_o, 1);
        serve(0, 2);
        check(overdue_o == 1'b1, "R8 overdue sticky", overdue_o, 1);
        overdue_clr_i = 1'b1;
        @(negedge clk);
        overdue_clr_i = 1'b0;
        check(overdue_o == 1'b0, "R8 overdue cleared", overdue_o, 0);
        wait_req(n);
        check(row_o == ROW_W'(3), "R8 dropped tick moves pointer once", row_o, 3);

        // R9: new period applies only from the next wrap
        period_i = CNT_W'(5);
        serve(0, 3);
        wait_req(n);
        check(RAS_CYC + 1 + n == P0 + 1, "R9 running countdown kept",
              RAS_CYC + 1 + n, P0 + 1);
        serve(0, 4);
        wait_req(n);
        check(RAS_CYC + 1 + n == 6, "R9 new period after wrap",
              RAS_CYC + 1 + n, 6);

        // R6: span reduced below the pointer wraps to 0
        last_row_i = ROW_W'(2);
        serve(0, 5);
        wait_req(n);
        check(row_o == 0, "R6 wrap when beyond last row", row_o, 0);
        check(overdue_o == 1'b0, "R8 no overdue after clear", overdue_o, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule